// File: doc/BRIEF.md
# UART Receiver with Per-Character Error Status

This block is the receive half of a serial port. It watches an asynchronous RXD line and takes its timing from an external enable that pulses at sixteen times the bit rate. It rebuilds characters of 5 to 8 data bits, with an optional parity bit, and judges each frame for parity, framing and break conditions. Every finished character becomes a 12-bit entry: the character itself plus four error flags that travel with it. Entries go into a receive FIFO, or into a single holding slot when the FIFO is switched off.

Software takes entries from a read port. A separate four-bit error-status register tracks the errors of the entry read most recently. The overrun flag in that register is the exception: it is raised the moment a character is lost. Any write to that register clears it. Empty and full flags describe the receive buffer. An RTS output can be tied to the free space in the buffer, so the far end pauses before characters are lost.

Top module: `uart_rx_err`

## Requirements
- R1: An entry holds the character right-aligned in bits 7..0, LSB received first, with unused upper bits zero; wordLen 0..3 selects 5..8 data bits. Bits 11..8 are the flags {overrun, break, parity error, framing error}; break is bit 10.
- R2: A falling edge on RXD starts a frame only if the line is still low 8 ticks later (mid start bit). Each later bit is sampled 16 ticks after the previous sample. A low pulse shorter than half a bit stores nothing.
- R3: With parity enabled, the bit after the data is checked as even parity (evenParity=1), odd parity (evenParity=0), or, with stickParity=1, as a fixed value equal to the inverse of evenParity. A mismatch sets bit 9 of the entry.
- R4: Status bits 2..0 (break, parity, framing) are loaded from bits 10..8 of the head entry only when that entry is popped through rdEn. At all other times they hold.
- R5: A character that completes while the buffer is full is discarded, and status bit 3 (overrun) is set in the next cycle. The next character that is stored carries bit 11 set.
- R6: A statusWr pulse clears all four status bits, whatever the data.
- R7: Only the first stop bit is checked. If it is low, bit 8 is set. A new start bit may follow directly after one stop bit.
- R8: With fifoEnable=0 the buffer holds one entry and rxFull rises as soon as it is occupied. With fifoEnable=1 it holds DEPTH entries. rxEmpty and rxFull are never both high, and rdData reads zero when the buffer is empty.
- R9: With rtsFlowEn=1, rtsOut equals rtsReq while the buffer has room and is low when it is full. With rtsFlowEn=0, rtsOut follows rtsReq.
- R10: Clearing rxEnable during a frame lets that frame finish and be stored. While rxEnable is low, no new frame is started.
- R11: If the line stays low through the whole frame, including the stop position, exactly one entry 0x500 (zero character, break and framing set) is stored. No further frame starts until the line returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| rxEnable | input | 1 | Allows new frames to start |
| fifoEnable | input | 1 | 1: DEPTH-entry FIFO, 0: single holding slot |
| wordLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | A parity bit follows the data |
| evenParity | input | 1 | Even parity when set, odd when clear |
| stickParity | input | 1 | Fixed parity value, the inverse of evenParity |
| rtsFlowEn | input | 1 | Gate rtsOut with buffer space |
| rtsReq | input | 1 | Software request-to-send level |
| rdEn | input | 1 | Pop the head entry and load status |
| rdData | output | 12 | Head entry, zero when empty |
| statusWr | input | 1 | Clear the error-status register |
| statusOut | output | 4 | {overrun, break, parity, framing} |
| rxEmpty | output | 1 | Buffer empty |
| rxFull | output | 1 | Buffer full for the current mode |
| rtsOut | output | 1 | Request to send, active high |

## Verification
The bench builds the block with DEPTH set to 4 and the default 16x oversampling. With that depth, FIFO-full, RTS withdrawal and overrun are reached after only a handful of frames, alongside the single-slot mode. The tick enable is driven every fourth clock, so a bit lasts 64 cycles and all word lengths, parity kinds, break and false-start cases fit in a short run. A behavioural queue model is compared against the flags, head entry, status and RTS on every clock once the line has settled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int ENTRY_W     = 12;
  localparam int BIT_FRAMING = 8;
  localparam int BIT_PARITY  = 9;
  localparam int BIT_BREAK   = 10;
  localparam int BIT_OVERRUN = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_WAITHIGH
  } rxState_e;

  // strobes from frame control to the datapath
  typedef struct packed {
    logic frameBegin;
    logic dataShift;
    logic parityCapture;
    logic stopCapture;
    logic sampledBit;
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       rxEnable,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  output rxStrobe_t  strobe
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST    = CW'(OVS - 1);

  logic rxMeta, rxSync;
  rxState_e state;
  logic [CW-1:0] tickCnt;
  logic [2:0] bitCnt;
  logic [2:0] lastBit;
  logic bitDone;

  // two-flop synchronizer, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
    end
  end

  assign lastBit = {1'b1, wordLen};
  assign bitDone = tick16 && (tickCnt == LAST);

  always_comb begin
    strobe = '0;
    strobe.sampledBit    = rxSync;
    strobe.frameBegin    = (state == ST_IDLE) && rxEnable && !rxSync;
    strobe.dataShift     = (state == ST_DATA) && bitDone;
    strobe.parityCapture = (state == ST_PARITY) && bitDone;
    strobe.stopCapture   = (state == ST_STOP) && bitDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rxEnable && !rxSync) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tick16) begin
            if (tickCnt == HALF_M1) begin
              tickCnt <= '0;
              bitCnt  <= '0;
              state   <= rxSync ? ST_IDLE : ST_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick16) begin
            if (tickCnt == LAST) begin
              tickCnt <= '0;
              if (bitCnt == lastBit) state <= parityEn ? ST_PARITY : ST_STOP;
              else bitCnt <= bitCnt + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_PARITY: begin
          if (tick16) begin
            if (tickCnt == LAST) begin
              tickCnt <= '0;
              state   <= ST_STOP;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick16) begin
            if (tickCnt == LAST) begin
              tickCnt <= '0;
              state   <= rxSync ? ST_IDLE : ST_WAITHIGH;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_WAITHIGH: begin
          if (rxSync) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  input  logic             singleSlot,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CNT_MAX  = (AW + 1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count;
  logic doPush, doPop;

  assign empty    = (count == '0);
  assign full     = singleSlot ? !empty : (count == CNT_MAX);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxStrobe_t          strobe,
  input  logic [1:0]         wordLen,
  input  logic               parityEn,
  input  logic               evenParity,
  input  logic               stickParity,
  input  logic               fifoEnable,
  input  logic               rdEn,
  input  logic               statusWr,
  input  logic               rtsFlowEn,
  input  logic               rtsReq,
  output logic [ENTRY_W-1:0] rdData,
  output logic [3:0]         statusOut,
  output logic               rxEmpty,
  output logic               rxFull,
  output logic               rtsOut,
  output logic               overrunEvt
);

  logic [7:0] shiftReg;
  logic [7:0] rxChar;
  logic anyOne, parBit, ovPending;
  logic expParity, frmErr, brkErr, parErr;
  logic [ENTRY_W-1:0] newEntry, headData;
  logic pushEvt, popEvt, fifoEmpty, fifoFull;
  logic [3:0] statusQ, statusNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      anyOne   <= 1'b0;
      parBit   <= 1'b0;
    end else if (strobe.frameBegin) begin
      shiftReg <= '0;
      anyOne   <= 1'b0;
      parBit   <= 1'b0;
    end else if (strobe.dataShift) begin
      shiftReg <= {strobe.sampledBit, shiftReg[7:1]};
      anyOne   <= anyOne | strobe.sampledBit;
    end else if (strobe.parityCapture) begin
      parBit   <= strobe.sampledBit;
      anyOne   <= anyOne | strobe.sampledBit;
    end
  end

  // bits arrive from the top, so right-align by the unused count
  assign rxChar = shiftReg >> (2'd3 - wordLen);

  always_comb begin
    if (stickParity)     expParity = !evenParity;
    else if (evenParity) expParity = ^rxChar;
    else                 expParity = ~^rxChar;
    frmErr = !strobe.sampledBit;
    brkErr = frmErr && !anyOne;
    parErr = parityEn && !brkErr && (parBit != expParity);
  end

  always_comb begin
    newEntry = '0;
    newEntry[7:0]         = rxChar;
    newEntry[BIT_FRAMING] = frmErr;
    newEntry[BIT_PARITY]  = parErr;
    newEntry[BIT_BREAK]   = brkErr;
    newEntry[BIT_OVERRUN] = ovPending;
  end

  assign pushEvt    = strobe.stopCapture && !fifoFull;
  assign overrunEvt = strobe.stopCapture && fifoFull;
  assign popEvt     = rdEn && !fifoEmpty;

  uart_rx_fifo #(
    .WIDTH(ENTRY_W),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rstN      (rstN),
    .push      (pushEvt),
    .pushData  (newEntry),
    .pop       (popEvt),
    .singleSlot(!fifoEnable),
    .headData  (headData),
    .empty     (fifoEmpty),
    .full      (fifoFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ovPending <= 1'b0;
    else if (overrunEvt) ovPending <= 1'b1;
    else if (pushEvt)    ovPending <= 1'b0;
  end

  always_comb begin
    statusNext = statusQ;
    if (statusWr)    statusNext = '0;
    else if (popEvt) statusNext = {statusQ[3], headData[BIT_BREAK:BIT_FRAMING]};
    if (overrunEvt)  statusNext[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusNext;
  end

  assign statusOut = statusQ;
  assign rdData    = fifoEmpty ? '0 : headData;
  assign rxEmpty   = fifoEmpty;
  assign rxFull    = fifoFull;
  assign rtsOut    = rtsReq && !(rtsFlowEn && fifoFull);

endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick16,
  input  logic        rxd,
  input  logic        rxEnable,
  input  logic        fifoEnable,
  input  logic [1:0]  wordLen,
  input  logic        parityEn,
  input  logic        evenParity,
  input  logic        stickParity,
  input  logic        rtsFlowEn,
  input  logic        rtsReq,
  input  logic        rdEn,
  output logic [11:0] rdData,
  input  logic        statusWr,
  output logic [3:0]  statusOut,
  output logic        rxEmpty,
  output logic        rxFull,
  output logic        rtsOut
);

  rxStrobe_t strobe;
  logic overrunEvt;

  uart_rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick16  (tick16),
    .rxd     (rxd),
    .rxEnable(rxEnable),
    .wordLen (wordLen),
    .parityEn(parityEn),
    .strobe  (strobe)
  );

  uart_rx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wordLen    (wordLen),
    .parityEn   (parityEn),
    .evenParity (evenParity),
    .stickParity(stickParity),
    .fifoEnable (fifoEnable),
    .rdEn       (rdEn),
    .statusWr   (statusWr),
    .rtsFlowEn  (rtsFlowEn),
    .rtsReq     (rtsReq),
    .rdData     (rdData),
    .statusOut  (statusOut),
    .rxEmpty    (rxEmpty),
    .rxFull     (rxFull),
    .rtsOut     (rtsOut),
    .overrunEvt (overrunEvt)
  );

endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk (
  input logic        clk,
  input logic        rstN,
  input logic        fifoEnable,
  input logic        rtsFlowEn,
  input logic        rdEn,
  input logic [11:0] rdData,
  input logic        statusWr,
  input logic [3:0]  statusOut,
  input logic        rxEmpty,
  input logic        rxFull,
  input logic        rtsOut,
  input logic        overrunEvt
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rxEmpty && rxFull)); // R8

  AST_SINGLE_SLOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEnable && !rxEmpty) |-> rxFull); // R8

  AST_RTS_WITHDRAWN: assert property (@(posedge clk) disable iff (!rstN)
    (rtsFlowEn && rxFull) |-> !rtsOut); // R9

  AST_READ_LOADS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rxEmpty && !statusWr) |=> (statusOut[2:0] == $past(rdData[10:8]))); // R4

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!(rdEn && !rxEmpty) && !statusWr && !overrunEvt) |=> $stable(statusOut)); // R4

  AST_OVERRUN_AT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    overrunEvt |=> statusOut[3]); // R5

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statusWr && !overrunEvt) |=> (statusOut == 4'h0)); // R6

endmodule

bind uart_rx_err uart_rx_err_chk u_chk (.*);

// File: tb/tb_uart_rx_err.sv
module tb_uart_rx_err;

  localparam int DEPTH   = 4;
  localparam int TICKDIV = 4;
  localparam int BITCLK  = 16 * TICKDIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic rxEnable = 1'b1, fifoEnable = 1'b1;
  logic [1:0] wordLen = 2'd3;
  logic parityEn = 1'b0, evenParity = 1'b0, stickParity = 1'b0;
  logic rtsFlowEn = 1'b0, rtsReq = 1'b1;
  logic rdEn = 1'b0, statusWr = 1'b0;
  logic [11:0] rdData;
  logic [3:0] statusOut;
  logic rxEmpty, rxFull, rtsOut;

  int checks = 0, fails = 0;
  int q[$];
  int statM = 0;
  bit ovPend = 0;
  bit settled = 0;
  bit done = 0;
  int tdiv = 0;

  uart_rx_err #(.DEPTH(DEPTH), .OVS(16)) dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxd(rxd), .rxEnable(rxEnable),
    .fifoEnable(fifoEnable), .wordLen(wordLen), .parityEn(parityEn),
    .evenParity(evenParity), .stickParity(stickParity), .rtsFlowEn(rtsFlowEn),
    .rtsReq(rtsReq), .rdEn(rdEn), .rdData(rdData), .statusWr(statusWr),
    .statusOut(statusOut), .rxEmpty(rxEmpty), .rxFull(rxFull), .rtsOut(rtsOut)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == TICKDIV - 1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == TICKDIV - 1);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int capacity();
    return fifoEnable ? DEPTH : 1;
  endfunction

  // per-clock comparison against the queue model
  always begin
    @(posedge clk);
    #2;
    if (settled && rstN && !done) begin
      check("R8 empty", rxEmpty, q.size() == 0);
      check("R8 full", rxFull, q.size() >= capacity());
      check("R1 head", rdData, (q.size() == 0) ? 0 : q[0]);
      check("R4 status", statusOut, statM);
      check("R9 rts", rtsOut, rtsReq && !(rtsFlowEn && q.size() >= capacity()));
    end
  end

  task automatic modelPush(input int e);
    if (q.size() >= capacity()) begin
      statM |= 8;
      ovPend = 1;
    end else begin
      q.push_back(e | (ovPend ? 'h800 : 0));
      ovPend = 0;
    end
  endtask

  task automatic sendBit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit badPar, input bit stopHigh,
                           input int disableAt, input int idleClks);
    int n;
    logic [7:0] m;
    logic p;
    int e;
    bit en;
    settled = 0;
    en = rxEnable;
    n = 5 + wordLen;
    m = d & 8'((1 << n) - 1);
    if (stickParity)     p = ~evenParity;
    else if (evenParity) p = ^m;
    else                 p = ~^m;
    if (badPar) p = ~p;
    sendBit(1'b0);
    for (int i = 0; i < n; i++) begin
      if (i == disableAt) rxEnable = 1'b0;
      sendBit(d[i]);
    end
    if (parityEn) sendBit(p);
    sendBit(stopHigh);
    rxd = 1'b1;
    repeat (idleClks) @(negedge clk);
    if (en) begin
      e = m;
      if (!stopHigh) e |= 'h100;
      if (parityEn && badPar) e |= 'h200;
      modelPush(e);
    end
    settled = 1;
  endtask

  task automatic sendBreak();
    int bits;
    settled = 0;
    bits = 1 + 5 + wordLen + (parityEn ? 1 : 0) + 1 + 1;
    rxd = 1'b0;
    repeat (bits * BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    modelPush('h500);
    settled = 1;
  endtask

  task automatic doRead(input string req, input int exp);
    @(negedge clk);
    rdEn = 1'b1;
    check(req, rdData, exp);
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      int e;
      e = q.pop_front();
      statM = (statM & 8) | ((e >> 8) & 7);
    end
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic clearStatus();
    @(negedge clk);
    statusWr = 1'b1;
    @(posedge clk);
    #1 statM = 0;
    @(negedge clk);
    statusWr = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset empty", rxEmpty, 1);
    check("R8 reset full", rxFull, 0);
    check("R1 reset data", rdData, 0);
    check("R4 reset status", statusOut, 0);
    settled = 1;

    // R1: 8-bit and 5-bit characters
    sendFrame(8'hA5, 0, 1, -1, 2 * BITCLK);
    doRead("R1 8-bit char", 'h0A5);
    wordLen = 2'd0;
    sendFrame(8'hFF, 0, 1, -1, 2 * BITCLK);
    doRead("R1 5-bit char", 'h01F);
    wordLen = 2'd3;

    // R3: even, odd and stick parity
    parityEn = 1; evenParity = 1;
    sendFrame(8'h03, 0, 1, -1, 2 * BITCLK);
    doRead("R3 even ok", 'h003);
    sendFrame(8'h07, 1, 1, -1, 2 * BITCLK);
    @(negedge clk);
    check("R4 status waits for read", statusOut, 0);
    doRead("R3 even bad", 'h207);
    @(negedge clk);
    check("R4 status after read", statusOut, 2);
    clearStatus();
    @(negedge clk);
    check("R6 cleared", statusOut, 0);
    evenParity = 0;
    sendFrame(8'h01, 1, 1, -1, 2 * BITCLK);
    doRead("R3 odd bad", 'h201);
    sendFrame(8'h01, 0, 1, -1, 2 * BITCLK);
    doRead("R3 odd ok", 'h001);
    stickParity = 1; evenParity = 1;
    sendFrame(8'h80, 0, 1, -1, 2 * BITCLK);
    doRead("R3 stick ok", 'h080);
    sendFrame(8'h80, 1, 1, -1, 2 * BITCLK);
    doRead("R3 stick bad", 'h280);
    clearStatus();
    parityEn = 0; stickParity = 0; evenParity = 0;

    // R7: framing error
    sendFrame(8'h55, 0, 0, -1, 2 * BITCLK);
    doRead("R7 framing", 'h155);
    @(negedge clk);
    check("R7 framing status", statusOut, 1);
    clearStatus();

    // R11: break
    sendBreak();
    @(negedge clk);
    check("R11 one entry stored", rxEmpty, 0);
    doRead("R11 break entry", 'h500);
    @(negedge clk);
    check("R11 single entry", rxEmpty, 1);
    check("R11 break status", statusOut, 5);
    clearStatus();

    // R2: short low pulse is not a start bit
    settled = 0;
    rxd = 1'b0;
    repeat (4 * TICKDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (16 * BITCLK) @(negedge clk);
    settled = 1;
    check("R2 false start ignored", rxEmpty, 1);

    // R7: back-to-back frames with one stop bit
    sendFrame(8'h3C, 0, 1, -1, 0);
    sendFrame(8'hC3, 0, 1, -1, 2 * BITCLK);
    doRead("R7 back-to-back 1", 'h03C);
    doRead("R7 back-to-back 2", 'h0C3);

    // R10: disable mid-character, then ignored while disabled
    sendFrame(8'h69, 0, 1, 3, 2 * BITCLK);
    doRead("R10 finished after disable", 'h069);
    sendFrame(8'h11, 0, 1, -1, 2 * BITCLK);
    @(negedge clk);
    check("R10 disabled ignores frame", rxEmpty, 1);
    rxEnable = 1'b1;

    // R8, R9, R5: single-slot mode
    fifoEnable = 0; rtsFlowEn = 1;
    @(negedge clk);
    check("R9 rts with room", rtsOut, 1);
    sendFrame(8'h12, 0, 1, -1, 2 * BITCLK);
    @(negedge clk);
    check("R8 single slot full", rxFull, 1);
    check("R9 rts withdrawn", rtsOut, 0);
    sendFrame(8'h34, 0, 1, -1, 2 * BITCLK);
    @(negedge clk);
    check("R5 overrun before read", statusOut, 8);
    doRead("R5 kept first char", 'h012);
    sendFrame(8'h56, 0, 1, -1, 2 * BITCLK);
    doRead("R5 overrun flag in entry", 'h856);
    clearStatus();

    // R8, R5: FIFO mode fill
    fifoEnable = 1;
    for (int i = 1; i <= 3; i++) sendFrame(8'(i), 0, 1, -1, 2 * BITCLK);
    @(negedge clk);
    check("R8 not full at 3", rxFull, 0);
    sendFrame(8'h04, 0, 1, -1, 2 * BITCLK);
    @(negedge clk);
    check("R8 full at depth", rxFull, 1);
    sendFrame(8'h05, 0, 1, -1, 2 * BITCLK);
    @(negedge clk);
    check("R5 FIFO overrun status", statusOut, 8);
    for (int i = 1; i <= 4; i++) doRead("R8 FIFO order", i);
    sendFrame(8'h06, 0, 1, -1, 2 * BITCLK);
    doRead("R5 FIFO overrun flag", 'h806);
    clearStatus();

    rtsFlowEn = 0; rtsReq = 0;
    @(negedge clk);
    check("R9 rts follows request", rtsOut, 0);
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule